// File: doc/BRIEF.md
# Prescaled Single-Channel PWM Timer

This block produces one pulse-width-modulated output from a pair of 32-bit word registers written over a simple strobe bus. A control word carries the run enable, a staging flag and a two-part prescaler selection. A count word carries the period length and the high-time length, both measured in prescaled ticks. The tick rate is the input clock divided by a power of two. The exponent is built from a 4-bit coarse field and a 1-bit fine field, and it is clamped to a configurable ceiling.

Software may stage a complete new setting while the staging flag is set. Clearing the flag releases the staged period, high time and exponent together. A running channel picks them up only at its next period boundary. A channel whose period or high time is zero refuses to run and holds its output low. A running channel therefore always drives at least one high tick per period.

Top module: `pwm_prescale_timer`

## Requirements
- R1: After reset both registers read as zero and `pwmOut` is low.
- R2: The control word (byte address 0) reads back the enable in bit 0, the staging flag in bit 11, the fine prescale bit in bit 15 and the coarse prescale field in bits 19:16. The count word (byte address 4) reads back the period in bits 25:16 and the high time in bits 9:0. All other bits read zero. Reads return the last written values, including values that are only staged.
- R3: The prescale exponent is twice the coarse field plus the fine bit. One tick lasts 2^exponent clock cycles, and one output period lasts period × 2^exponent cycles.
- R4: An exponent above MAX_EXP (24 by default) behaves exactly like MAX_EXP.
- R5: While the channel runs, the output is high for the first high-time ticks of each period and low for the rest. A high time equal to or above the period gives a constant-high output.
- R6: While the active period or high time is zero, the channel does not run and the output stays low, even with the enable set.
- R7: While the staging flag is 1, writes to the count word and to the prescale fields do not change the output waveform.
- R8: Clearing the staging flag applies all staged values together at the next period boundary of a running channel. No period mixes old and new values.
- R9: Clearing the enable drives the output low from the next cycle and resets both counters. A later enable restarts with a full high time.
- R10: With the staging flag at 0, a write to the count word takes effect at the next period boundary of a running channel, or at once on a stopped channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrStrobe | input | 1 | One-cycle write strobe for a full word |
| addr | input | ADDR_W | Byte address used for both reads and writes |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr`, combinational |
| pwmOut | output | 1 | PWM output |

## Verification
The assertions assume that every write is a full word sampled on a one-cycle strobe. They also assume that the active setting can change only while the channel is stopped or at a period boundary, so any change seen mid-period points to a design fault. The stimulus always sets up a fresh configuration with the channel disabled and the staging flag clear. It changes a running channel only through the staging flag or through a plain count write, and it waits for whole periods before it measures the output. Random periods, high times and exponents stay small enough that every measured period fits well inside the run. The bench lowers the exponent ceiling so that the clamp can be seen in a few hundred cycles.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;

  // register field positions that software decodes
  localparam int EN_BIT      = 0;
  localparam int SYNC_BIT    = 11;
  localparam int FINE_BIT    = 15;
  localparam int COARSE_LSB  = 16;
  localparam int COARSE_W    = 4;
  localparam int PERIOD_LSB  = 16;
  localparam int HIGH_LSB    = 0;
  localparam int WORD_W      = 32;

  // strobes from the register/sequencing side to the datapath
  typedef struct packed {
    logic runEn;
    logic loadActive;
  } pwmStrobe_t;

endpackage

// File: rtl/pwmt_regs.sv
module pwmt_regs
  import pwmt_pkg::*;
#(
  parameter int MAX_EXP = 24,
  parameter int CNT_W   = 10,
  parameter int ADDR_W  = 3,
  localparam int EXP_W  = $clog2(MAX_EXP + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStrobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wrData,
  input  logic              running,
  input  logic              boundary,
  output logic [WORD_W-1:0] rdData,
  output pwmStrobe_t        strobe,
  output logic [CNT_W-1:0]  stagedPeriod,
  output logic [CNT_W-1:0]  stagedHigh,
  output logic [EXP_W-1:0]  stagedExp
);

  localparam logic [ADDR_W-1:0] CTRL_ADDR  = '0;
  localparam logic [ADDR_W-1:0] COUNT_ADDR = ADDR_W'(4);
  localparam int RAW_W = COARSE_W + 1;

  logic                enQ, syncQ, fineSh;
  logic [COARSE_W-1:0] coarseSh;
  logic [CNT_W-1:0]    periodSh, highSh;
  logic                commitReq, pendingQ;
  logic                wrCtrl, wrCount;
  logic [RAW_W-1:0]    rawExp;
  logic [EXP_W-1:0]    clampExp;

  assign wrCtrl  = wrStrobe && (addr == CTRL_ADDR);
  assign wrCount = wrStrobe && (addr == COUNT_ADDR);

  // software-visible (shadow) registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ      <= 1'b0;
      syncQ    <= 1'b0;
      fineSh   <= 1'b0;
      coarseSh <= '0;
      periodSh <= '0;
      highSh   <= '0;
    end else begin
      if (wrCtrl) begin
        enQ      <= wrData[EN_BIT];
        syncQ    <= wrData[SYNC_BIT];
        fineSh   <= wrData[FINE_BIT];
        coarseSh <= wrData[COARSE_LSB +: COARSE_W];
      end
      if (wrCount) begin
        periodSh <= wrData[PERIOD_LSB +: CNT_W];
        highSh   <= wrData[HIGH_LSB +: CNT_W];
      end
    end
  end

  // exponent = coarse*2 + fine, clamped to the ceiling
  assign rawExp   = {coarseSh, fineSh};
  assign clampExp = (int'(rawExp) > MAX_EXP) ? EXP_W'(MAX_EXP) : EXP_W'(rawExp);

  // commit: shadow -> staged copy, then staged -> active at a safe point
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      commitReq    <= 1'b0;
      pendingQ     <= 1'b0;
      stagedPeriod <= '0;
      stagedHigh   <= '0;
      stagedExp    <= '0;
    end else begin
      commitReq <= (wrCount && !syncQ) || (wrCtrl && !wrData[SYNC_BIT]);
      if (commitReq) begin
        stagedPeriod <= periodSh;
        stagedHigh   <= highSh;
        stagedExp    <= clampExp;
        pendingQ     <= 1'b1;
      end else if (strobe.loadActive) begin
        pendingQ <= 1'b0;
      end
    end
  end

  always_comb begin
    strobe.runEn      = enQ;
    strobe.loadActive = pendingQ && (!running || boundary);
  end

  // read mux
  always_comb begin
    rdData = '0;
    if (addr == CTRL_ADDR) begin
      rdData[EN_BIT]                  = enQ;
      rdData[SYNC_BIT]                = syncQ;
      rdData[FINE_BIT]                = fineSh;
      rdData[COARSE_LSB +: COARSE_W]  = coarseSh;
    end else if (addr == COUNT_ADDR) begin
      rdData[PERIOD_LSB +: CNT_W] = periodSh;
      rdData[HIGH_LSB +: CNT_W]   = highSh;
    end
  end

endmodule

// File: rtl/pwmt_core.sv
module pwmt_core
  import pwmt_pkg::*;
#(
  parameter int MAX_EXP = 24,
  parameter int CNT_W   = 10,
  localparam int EXP_W  = $clog2(MAX_EXP + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  pwmStrobe_t       strobe,
  input  logic [CNT_W-1:0] stagedPeriod,
  input  logic [CNT_W-1:0] stagedHigh,
  input  logic [EXP_W-1:0] stagedExp,
  output logic             pwmOut,
  output logic             running,
  output logic             boundary,
  output logic [CNT_W-1:0] actPeriod,
  output logic [CNT_W-1:0] actHigh,
  output logic [CNT_W-1:0] perCnt
);

  logic [EXP_W-1:0]   actExp;
  logic [MAX_EXP-1:0] preCnt;
  logic [MAX_EXP-1:0] tickMask;
  logic               tick;

  // active setting, replaced only on a load strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actPeriod <= '0;
      actHigh   <= '0;
      actExp    <= '0;
    end else if (strobe.loadActive) begin
      actPeriod <= stagedPeriod;
      actHigh   <= stagedHigh;
      actExp    <= stagedExp;
    end
  end

  assign running = strobe.runEn && (actPeriod != '0) && (actHigh != '0);

  // thermometer mask of the low prescaler bits that must all be set for a tick
  for (genvar gi = 0; gi < MAX_EXP; gi++) begin : g_mask
    assign tickMask[gi] = (actExp > EXP_W'(gi));
  end

  assign tick     = running && (preCnt == tickMask);
  assign boundary = tick && (perCnt == actPeriod - 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      perCnt <= '0;
    end else if (!running) begin
      preCnt <= '0;
      perCnt <= '0;
    end else begin
      preCnt <= tick ? '0 : preCnt + 1'b1;
      if (boundary)  perCnt <= '0;
      else if (tick) perCnt <= perCnt + 1'b1;
    end
  end

  assign pwmOut = running && (perCnt < actHigh);

endmodule

// File: rtl/pwm_prescale_timer.sv
module pwm_prescale_timer
  import pwmt_pkg::*;
#(
  parameter int MAX_EXP = 24,
  parameter int CNT_W   = 10,
  parameter int ADDR_W  = 3,
  localparam int EXP_W  = $clog2(MAX_EXP + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStrobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output logic              pwmOut
);

  pwmStrobe_t       strobe;
  logic [CNT_W-1:0] stagedPeriod, stagedHigh;
  logic [EXP_W-1:0] stagedExp;
  logic             running, boundary;
  logic [CNT_W-1:0] actPeriod, actHigh, perCnt;

  pwmt_regs #(.MAX_EXP(MAX_EXP), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) regs (
    .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .addr(addr), .wrData(wrData),
    .running(running), .boundary(boundary), .rdData(rdData), .strobe(strobe),
    .stagedPeriod(stagedPeriod), .stagedHigh(stagedHigh), .stagedExp(stagedExp)
  );

  pwmt_core #(.MAX_EXP(MAX_EXP), .CNT_W(CNT_W)) core (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .stagedPeriod(stagedPeriod), .stagedHigh(stagedHigh), .stagedExp(stagedExp),
    .pwmOut(pwmOut), .running(running), .boundary(boundary),
    .actPeriod(actPeriod), .actHigh(actHigh), .perCnt(perCnt)
  );

endmodule

// File: rtl/pwm_prescale_timer_chk.sv
module pwm_prescale_timer_chk #(
  parameter int CNT_W  = 10,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrStrobe,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wrData,
  input logic              pwmOut,
  input logic              running,
  input logic              boundary,
  input logic [CNT_W-1:0]  actPeriod,
  input logic [CNT_W-1:0]  actHigh,
  input logic [CNT_W-1:0]  perCnt
);

  // R9: a write that clears the enable silences the output on the next cycle
  assert_disable_low_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && addr == '0 && !wrData[0]) |=> !pwmOut);

  // R6: a zero period or high time keeps the output low
  assert_zero_guard_R6: assert property (@(posedge clk) disable iff (!rstN)
    (actPeriod == '0 || actHigh == '0) |-> !pwmOut);

  // R5: high time at or above the period means constant high while running
  assert_const_high_R5: assert property (@(posedge clk) disable iff (!rstN)
    (running && actHigh >= actPeriod) |-> pwmOut);

  // R5: every running period begins with a high tick
  assert_period_start_high_R5: assert property (@(posedge clk) disable iff (!rstN)
    (running && perCnt == '0) |-> pwmOut);

  // R8: the active setting moves only while stopped or on a period boundary
  assert_atomic_update_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(actPeriod) || !$stable(actHigh)) |-> $past(!running || boundary));

endmodule

bind pwm_prescale_timer pwm_prescale_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) chk (
  .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .addr(addr), .wrData(wrData),
  .pwmOut(pwmOut), .running(running), .boundary(boundary),
  .actPeriod(actPeriod), .actHigh(actHigh), .perCnt(perCnt)
);

// File: tb/pwm_prescale_timer_test.sv
module pwm_prescale_timer_test;

  localparam int TB_MAX_EXP = 8;
  localparam int LIM        = 20000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrStrobe = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        pwmOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pwm_prescale_timer #(.MAX_EXP(TB_MAX_EXP), .CNT_W(10), .ADDR_W(3)) uut (
    .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .addr(addr),
    .wrData(wrData), .rdData(rdData), .pwmOut(pwmOut)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic logic [31:0] ctrlWord(bit en, bit sync, int coarse, bit fine);
    logic [31:0] w = '0;
    w[0] = en; w[11] = sync; w[15] = fine; w[19:16] = 4'(coarse);
    return w;
  endfunction

  function automatic logic [31:0] countWord(int per, int hi);
    logic [31:0] w = '0;
    w[25:16] = 10'(per); w[9:0] = 10'(hi);
    return w;
  endfunction

  function automatic int expOf(int coarse, bit fine);
    int e = coarse * 2 + int'(fine);
    return (e > TB_MAX_EXP) ? TB_MAX_EXP : e;
  endfunction

  task automatic writeReg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrStrobe = 1'b1;
    @(negedge clk);
    wrStrobe = 1'b0;
  endtask

  task automatic readReg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdData;
  endtask

  task automatic setup(input int per, input int hi, input int coarse, input bit fine);
    writeReg(3'd0, ctrlWord(0, 0, coarse, fine));
    writeReg(3'd4, countWord(per, hi));
    repeat (4) @(negedge clk);
    writeReg(3'd0, ctrlWord(1, 0, coarse, fine));
  endtask

  // one full period, from a rising edge to the next
  task automatic measure(output int hi, output int len);
    int g = 0;
    while (pwmOut !== 1'b0 && g < LIM) begin @(negedge clk); g++; end
    while (pwmOut !== 1'b1 && g < LIM) begin @(negedge clk); g++; end
    hi = 0; len = 0;
    while (pwmOut === 1'b1 && g < LIM) begin hi++; len++; @(negedge clk); g++; end
    while (pwmOut === 1'b0 && g < LIM) begin len++; @(negedge clk); g++; end
  endtask

  task automatic holdCheck(input bit level, input int n, input string req);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwmOut !== level) bad++;
    end
    check(bad == 0, req, bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int hi, len, e;
    void'($urandom(20240611));

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    readReg(3'd0, d); check(d == 0, "R1 ctrl", int'(d), 0);
    readReg(3'd4, d); check(d == 0, "R1 count", int'(d), 0);
    check(pwmOut === 1'b0, "R1 out", int'(pwmOut), 0);

    // R2 readback, unused bits stay zero
    writeReg(3'd0, 32'hFFFF_FFFE);
    readReg(3'd0, d); check(d == 32'h000F_8800, "R2 ctrl", int'(d), 32'h000F_8800);
    writeReg(3'd4, 32'hFFFF_FFFF);
    readReg(3'd4, d); check(d == 32'h03FF_03FF, "R2 count", int'(d), 32'h03FF_03FF);
    writeReg(3'd0, 32'h0);
    writeReg(3'd4, 32'h0);

    // R3 / R5 directed
    setup(6, 2, 0, 1);
    measure(hi, len);
    check(len == 12, "R3 period e1", len, 12);
    check(hi == 4, "R5 high e1", hi, 4);

    // R3 / R5 random configurations
    for (int k = 0; k < 12; k++) begin
      int per = 1 + int'($urandom % 20);
      int ph  = 1 + int'($urandom % 18);
      int co  = int'($urandom % 2);
      bit fi  = 1'($urandom % 2);
      e = expOf(co, fi);
      setup(per, ph, co, fi);
      if (ph >= per) begin
        holdCheck(1'b1, 3 * (per << e), "R5 const high random");
      end else begin
        measure(hi, len);
        check(len == (per << e), "R3 period random", len, per << e);
        check(hi == (ph << e), "R5 high random", hi, ph << e);
      end
    end

    // R5 equal high time and period
    setup(4, 4, 0, 0);
    holdCheck(1'b1, 20, "R5 equal const high");

    // R4 clamp: raw exponent 9 and 31 both act as 8
    setup(2, 1, 4, 1);
    measure(hi, len);
    check(len == 512, "R4 clamp 9", len, 512);
    setup(2, 1, 15, 1);
    measure(hi, len);
    check(hi == 256, "R4 clamp 31", hi, 256);

    // R6 zero guard
    setup(5, 0, 0, 0);
    holdCheck(1'b0, 30, "R6 zero high");
    setup(0, 3, 0, 0);
    holdCheck(1'b0, 30, "R6 zero period");

    // R9 disable and restart
    setup(10, 4, 0, 0);
    measure(hi, len);
    while (pwmOut !== 1'b1) @(negedge clk);
    writeReg(3'd0, ctrlWord(0, 0, 0, 0));
    check(pwmOut === 1'b0, "R9 off at once", int'(pwmOut), 0);
    repeat (5) @(negedge clk);
    writeReg(3'd0, ctrlWord(1, 0, 0, 0));
    hi = 0;
    while (pwmOut === 1'b1 && hi < 100) begin hi++; @(negedge clk); end
    check(hi == 4, "R9 full high after restart", hi, 4);

    // R7 staging: A = (6,2,e1) stays while new setting is staged
    setup(6, 2, 0, 1);
    writeReg(3'd0, ctrlWord(1, 1, 1, 0));
    writeReg(3'd4, countWord(9, 5));
    measure(hi, len);
    measure(hi, len);
    check(len == 12 && hi == 4, "R7 unchanged while staged", len * 100 + hi, 1204);
    readReg(3'd4, d); check(d == countWord(9, 5), "R2 staged readback", int'(d), int'(countWord(9, 5)));

    // R8 release: every period is old or new, ending on new (36,20)
    writeReg(3'd0, ctrlWord(1, 0, 1, 0));
    for (int p = 0; p < 4; p++) begin
      measure(hi, len);
      check((len == 12 && hi == 4) || (len == 36 && hi == 20), "R8 no mixed period", len * 100 + hi, 3620);
    end
    check(len == 36 && hi == 20, "R8 new setting applied", len * 100 + hi, 3620);

    // R10 direct count write while running
    writeReg(3'd4, countWord(5, 1));
    measure(hi, len);
    measure(hi, len);
    check(len == 20 && hi == 4, "R10 direct update", len * 100 + hi, 2004);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule